// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address into a 36-bit physical address. It reads page table entries from memory and follows them down through three levels. The top level is a small table of four 8-byte pointers, and a root pointer input gives its location. Each pointer selects a 512-entry page directory. A directory entry points either to a 512-entry page table, whose entries map 4 KiB pages, or, when its large-page flag is set, straight to a 2 MiB page.

A translation starts with a single-cycle request that carries the virtual address and an instruction-fetch flag. While the walk is in progress `busy` stays high. The block issues one 64-bit entry read at a time on a request/response memory port, and it waits for each response before it forms the next address. At the end it raises `done` for one cycle and presents either the physical address and the page size, or a fault code. A request is rejected at once if the enable bit of the control word is clear.

Top module: `pt_walker`

## Requirements
- R1: After reset, `busy`, `done` and `mem_req` are all low.
- R2: A request is taken only while `busy` is low. A `req_valid` pulse seen while a walk is running causes no memory read and does not change the result.
- R3: If bit 5 of `ctrl_reg` is clear, a request makes no memory read. `done` rises one cycle after the request, with `flt_code` = 1 (mode off).
- R4: The first read address is {`root_ptr`[35:5], va[31:30], 3'b000}.
- R5: Each later read address is {previous entry[35:12], index, 3'b000}. The index is va[29:21] for the directory read and va[20:12] for the table read. Entry bits 11:0 and 62:36 never take part in an address.
- R6: When a 4 KiB walk succeeds, it takes 3 reads and gives `paddr` = {table entry[35:12], va[11:0]}, `large_page` = 0 and `flt_code` = 0.
- R7: If bit 7 of a directory entry is set, the walk stops after 2 reads. It gives `paddr` = {entry[35:21], va[20:0]} and `large_page` = 1. Bits 20:12 of that entry are ignored.
- R8: If bit 0 of an entry is clear, the walk stops after that read with `flt_code` = 2 (not present). `flt_level` gives the failing level: 0 for the pointer table, 1 for the directory, 2 for the table.
- R9: If bit 63 of the final (leaf) entry is set and `req_ifetch` was high, the result is `flt_code` = 3 (no-execute). With `req_ifetch` low, the same walk succeeds.
- R10: `mem_req` is a single-cycle pulse. No new pulse is issued until `mem_rvalid` has returned for the previous one.
- R11: `done` is a single-cycle pulse, and `busy` is low whenever `done` is high. The result outputs hold their values until the next `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request pulse |
| req_vaddr | input | 32 | Virtual address to translate |
| req_ifetch | input | 1 | Request is an instruction fetch |
| root_ptr | input | 36 | Physical base of the pointer table |
| ctrl_reg | input | 32 | Control word; bit 5 enables translation |
| busy | output | 1 | Walk in progress |
| mem_req | output | 1 | Entry read request pulse |
| mem_addr | output | 36 | Entry read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Entry read data |
| done | output | 1 | Result valid pulse |
| paddr | output | 36 | Translated physical address |
| large_page | output | 1 | Result maps a 2 MiB page |
| flt_code | output | 2 | 0 none, 1 mode off, 2 not present, 3 no-execute |
| flt_level | output | 2 | Level of the entry that faulted |

## Verification
Some properties are checked on every cycle. Every read address is 8-byte aligned. The page offset passes through unchanged on both 4 KiB and 2 MiB results. A no-execute fault only ever follows an instruction fetch. Read pulses stay single-cycle and never overlap an outstanding read. `done` never coincides with `busy`, and a walk never starts while the mode bit is off. Other behaviour only shows up in the bench scenarios: the exact sequence of read addresses, the read count for each page size, the level reported for each absent entry, and the proof that requests made during a walk leave no trace.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int VA_W   = 32,
  parameter int PA_W   = 36,
  parameter int ENT_W  = 64,
  parameter int CTRL_W = 32,
  parameter int EN_BIT = 5,
  parameter int PS_BIT = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic              req_ifetch,
  input  logic [PA_W-1:0]   root_ptr,
  input  logic [CTRL_W-1:0] ctrl_reg,
  output logic              busy,
  output logic              mem_req,
  output logic [PA_W-1:0]   mem_addr,
  input  logic              mem_rvalid,
  input  logic [ENT_W-1:0]  mem_rdata,
  output logic              done,
  output logic [PA_W-1:0]   paddr,
  output logic              large_page,
  output logic [1:0]        flt_code,
  output logic [1:0]        flt_level
);
  localparam int OFF_W  = 12;
  localparam int IDX_W  = 9;
  localparam int TOP_W  = VA_W - OFF_W - 2 * IDX_W;
  localparam int BIG_W  = OFF_W + IDX_W;
  localparam int NX_BIT = ENT_W - 1;
  localparam logic [1:0] F_NONE = 2'd0, F_MODE = 2'd1, F_NP = 2'd2, F_NX = 2'd3;

  typedef enum logic {S_IDLE, S_WAIT} st_t;
  st_t st;
  logic [1:0]      lvl;
  logic [VA_W-1:0] va_q;
  logic            if_q;

  wire [PA_W-OFF_W-1:0] ent_base = mem_rdata[PA_W-1:OFF_W];
  wire ent_p  = mem_rdata[0];
  wire ent_ps = mem_rdata[PS_BIT];
  wire ent_nx = mem_rdata[NX_BIT];

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      lvl <= '0;
      va_q <= '0;
      if_q <= 1'b0;
      mem_req <= 1'b0;
      mem_addr <= '0;
      done <= 1'b0;
      paddr <= '0;
      large_page <= 1'b0;
      flt_code <= F_NONE;
      flt_level <= '0;
    end else begin
      mem_req <= 1'b0;
      done <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          va_q <= req_vaddr;
          if_q <= req_ifetch;
          if (!ctrl_reg[EN_BIT]) begin
            done <= 1'b1;
            flt_code <= F_MODE;
            flt_level <= '0;
            paddr <= '0;
            large_page <= 1'b0;
          end else begin
            mem_req <= 1'b1;
            mem_addr <= {root_ptr[PA_W-1:TOP_W+3], req_vaddr[VA_W-1 -: TOP_W], 3'b000};
            lvl <= 2'd0;
            st <= S_WAIT;
          end
        end
        S_WAIT: if (mem_rvalid) begin
          if (!ent_p) begin
            st <= S_IDLE;
            done <= 1'b1;
            flt_code <= F_NP;
            flt_level <= lvl;
            paddr <= '0;
            large_page <= 1'b0;
          end else if (lvl == 2'd0) begin
            mem_req <= 1'b1;
            mem_addr <= {ent_base, va_q[VA_W-TOP_W-1 -: IDX_W], 3'b000};
            lvl <= 2'd1;
          end else if (lvl == 2'd1 && !ent_ps) begin
            mem_req <= 1'b1;
            mem_addr <= {ent_base, va_q[BIG_W-1 -: IDX_W], 3'b000};
            lvl <= 2'd2;
          end else begin
            st <= S_IDLE;
            done <= 1'b1;
            flt_level <= lvl;
            if (ent_nx && if_q) begin
              flt_code <= F_NX;
              paddr <= '0;
              large_page <= 1'b0;
            end else begin
              flt_code <= F_NONE;
              large_page <= (lvl == 2'd1);
              paddr <= (lvl == 2'd1) ? {mem_rdata[PA_W-1:BIG_W], va_q[BIG_W-1:0]}
                                     : {ent_base, va_q[OFF_W-1:0]};
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R4 R5
  addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[2:0] == 3'b000);

  // R6
  small_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && flt_code == F_NONE && !large_page) |-> paddr[OFF_W-1:0] == va_q[OFF_W-1:0]);

  // R7
  large_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && flt_code == F_NONE && large_page) |-> paddr[BIG_W-1:0] == va_q[BIG_W-1:0]);

  // R9
  nx_fetch_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && flt_code == F_NX) |-> if_q);

  // R10
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  // R10
  req_after_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> ($past(!busy) || $past(mem_rvalid)));

  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R3
  mode_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(ctrl_reg[EN_BIT]));
endmodule

// File: tb/pt_walker_test.sv
module pt_walker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_ifetch = 1'b0;
  logic [35:0] root_ptr = 36'h0_0010_0000;
  logic [31:0] ctrl_reg = 32'h0000_0020;
  logic        busy, mem_req, done, large_page;
  logic [35:0] mem_addr, paddr;
  logic        mem_rvalid = 1'b0;
  logic [63:0] mem_rdata = '0;
  logic [1:0]  flt_code, flt_level;

  pt_walker uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_ifetch(req_ifetch), .root_ptr(root_ptr), .ctrl_reg(ctrl_reg),
    .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .done(done), .paddr(paddr), .large_page(large_page),
    .flt_code(flt_code), .flt_level(flt_level)
  );

  always #10 clk = ~clk;

  localparam logic [35:0] DIR_BASE = 36'h0_0020_0000;
  localparam logic [35:0] TBL_BASE = 36'h0_0030_0000;

  logic [63:0] mem_img [logic [35:0]];
  logic [35:0] rd_log [0:3];
  int          nreads = 0;
  int          lat = 0;
  logic [35:0] lat_addr = '0;
  logic        clr_log = 1'b0;
  int          overlaps = 0;
  int          vectors = 0;
  int          errors = 0;

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (lat != 0) begin
      lat <= lat - 1;
      if (lat == 1) begin
        mem_rvalid <= 1'b1;
        mem_rdata <= mem_img.exists(lat_addr) ? mem_img[lat_addr] : 64'h0;
      end
    end
    if (clr_log) begin
      nreads <= 0;
      overlaps <= 0;
    end else if (mem_req) begin
      if (lat != 0) overlaps <= overlaps + 1;
      lat <= 3;
      lat_addr <= mem_addr;
      if (nreads < 4) rd_log[nreads] <= mem_addr;
      nreads <= nreads + 1;
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_ent(input bit nx, input logic [35:0] base, input logic [11:0] flags);
    return {nx, 27'h5A5A5A5, base[35:12], flags};
  endfunction

  function automatic logic [35:0] top_addr(input logic [31:0] va);
    return {root_ptr[35:5], va[31:30], 3'b000};
  endfunction

  function automatic logic [35:0] dir_addr(input logic [31:0] va);
    return {DIR_BASE[35:12], va[29:21], 3'b000};
  endfunction

  function automatic logic [35:0] tbl_addr(input logic [31:0] va);
    return {TBL_BASE[35:12], va[20:12], 3'b000};
  endfunction

  task automatic run_walk(input logic [31:0] va, input bit ifetch, output int cyc);
    @(negedge clk);
    clr_log = 1'b1;
    @(negedge clk);
    clr_log = 1'b0;
    req_vaddr = va;
    req_ifetch = ifetch;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1;
    while (!done && cyc < 200) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic t_reset();
    check(!busy, "R1 busy", busy, 0);
    check(!done, "R1 done", done, 0);
    check(!mem_req, "R1 mem_req", mem_req, 0);
  endtask

  task automatic t_small(input logic [31:0] va, input logic [35:0] pg, input bit nx, input bit ifetch);
    int cyc;
    logic [35:0] exp_pa;
    mem_img[top_addr(va)] = mk_ent(1'b1, DIR_BASE, 12'hE61);
    mem_img[dir_addr(va)] = mk_ent(1'b1, TBL_BASE, 12'h063);
    mem_img[tbl_addr(va)] = mk_ent(nx, pg, 12'hFFF);
    run_walk(va, ifetch, cyc);
    check(done, "R6 done seen", done, 1);
    check(nreads == 3, "R6 read count", nreads, 3);
    check(overlaps == 0, "R10 overlap", overlaps, 0);
    check(rd_log[0] == top_addr(va), "R4 top addr", rd_log[0], top_addr(va));
    check(rd_log[1] == dir_addr(va), "R5 dir addr", rd_log[1], dir_addr(va));
    check(rd_log[2] == tbl_addr(va), "R5 tbl addr", rd_log[2], tbl_addr(va));
    if (nx && ifetch) begin
      check(flt_code == 2'd3, "R9 nx fault", flt_code, 3);
    end else begin
      exp_pa = {pg[35:12], va[11:0]};
      check(flt_code == 2'd0, "R6 no fault", flt_code, 0);
      check(paddr == exp_pa, "R6 paddr", paddr, exp_pa);
      check(!large_page, "R6 small page", large_page, 0);
    end
    @(negedge clk);
    check(!done, "R11 done pulse", done, 0);
  endtask

  task automatic t_large(input logic [31:0] va, input logic [35:0] pg, input bit nx, input bit ifetch);
    int cyc;
    logic [63:0] ent;
    logic [35:0] exp_pa;
    ent = mk_ent(nx, pg | 36'h0_001F_F000, 12'h0A1);
    mem_img[top_addr(va)] = mk_ent(1'b0, DIR_BASE, 12'h001);
    mem_img[dir_addr(va)] = ent;
    run_walk(va, ifetch, cyc);
    check(nreads == 2, "R7 read count", nreads, 2);
    check(rd_log[1] == dir_addr(va), "R5 dir addr large", rd_log[1], dir_addr(va));
    if (nx && ifetch) begin
      check(flt_code == 2'd3, "R9 nx large", flt_code, 3);
    end else begin
      exp_pa = {ent[35:21], va[20:0]};
      check(flt_code == 2'd0, "R7 no fault", flt_code, 0);
      check(paddr == exp_pa, "R7 paddr", paddr, exp_pa);
      check(large_page, "R7 large flag", large_page, 1);
    end
  endtask

  task automatic t_absent(input logic [31:0] va, input int level);
    int cyc;
    mem_img[top_addr(va)] = mk_ent(1'b0, DIR_BASE, (level == 0) ? 12'hFFE : 12'h001);
    mem_img[dir_addr(va)] = mk_ent(1'b0, TBL_BASE, (level == 1) ? 12'hFFE : 12'h001);
    mem_img[tbl_addr(va)] = mk_ent(1'b0, 36'h1_2345_6000, (level == 2) ? 12'hFFE : 12'h001);
    run_walk(va, 1'b0, cyc);
    check(flt_code == 2'd2, "R8 np code", flt_code, 2);
    check(flt_level == level[1:0], "R8 np level", flt_level, level);
    check(nreads == level + 1, "R8 reads", nreads, level + 1);
  endtask

  task automatic t_mode_off(input logic [31:0] ctrl);
    int cyc;
    ctrl_reg = ctrl;
    run_walk(32'h4060_3ABC, 1'b0, cyc);
    check(cyc == 1, "R3 latency", cyc, 1);
    check(flt_code == 2'd1, "R3 code", flt_code, 1);
    check(nreads == 0, "R3 no reads", nreads, 0);
    ctrl_reg = 32'h0000_0020;
  endtask

  task automatic t_busy_block();
    int cyc;
    logic [31:0] va = 32'hC1A0_5123;
    logic [35:0] pg = 36'hF_0000_1000;
    mem_img[top_addr(va)] = mk_ent(1'b0, DIR_BASE, 12'h001);
    mem_img[dir_addr(va)] = mk_ent(1'b0, TBL_BASE, 12'h001);
    mem_img[tbl_addr(va)] = mk_ent(1'b0, pg, 12'h001);
    @(negedge clk);
    clr_log = 1'b1;
    @(negedge clk);
    clr_log = 1'b0;
    req_vaddr = va;
    req_valid = 1'b1;
    @(negedge clk);
    req_vaddr = 32'h0000_0FFF;
    @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 0;
    while (!done && cyc < 200) begin
      @(negedge clk);
      cyc++;
    end
    check(nreads == 3, "R2 reads during busy", nreads, 3);
    check(paddr == {pg[35:12], va[11:0]}, "R2 result kept", paddr, {pg[35:12], va[11:0]});
    for (int k = 0; k < 10; k++) @(negedge clk);
    check(nreads == 3, "R2 no late walk", nreads, 3);
    check(paddr == {pg[35:12], va[11:0]}, "R11 result held", paddr, {pg[35:12], va[11:0]});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_small(32'h4060_3ABC, 36'h9_8765_4000, 1'b0, 1'b0);
    t_small(32'hFFFF_F001, 36'hA_BCDE_F000, 1'b0, 1'b1);
    t_small(32'h0000_0000, 36'h0_0000_0000, 1'b1, 1'b1);
    t_small(32'h8123_4567, 36'h3_3333_3000, 1'b1, 1'b0);
    t_large(32'h7ABC_DEF0, 36'h7_6540_0000, 1'b0, 1'b0);
    t_large(32'h3FFF_FFFF, 36'hF_FFE0_0000, 1'b1, 1'b1);
    t_large(32'hC020_0001, 36'h1_0020_0000, 1'b1, 1'b0);
    t_absent(32'h1234_5678, 0);
    t_absent(32'h5555_AAAA, 1);
    t_absent(32'hBEEF_0123, 2);
    t_mode_off(32'h0000_0000);
    t_mode_off(32'hFFFF_FFDF);
    t_busy_block();
    finish_run();
  end
endmodule